// File: doc/BRIEF.md
# Serial-Loaded Switch Enable Register

This block holds eight on/off switch enables and loads them from a three-wire serial port. The port has an active-low frame line, a serial clock and a serial data input. All three inputs are sampled by a fast system clock through two-stage synchronizers. Edges of the serial clock and of the frame line are found inside the block, so all logic runs in the system clock domain.

While the frame line is low, each falling serial-clock edge shifts one bit into an eight-bit collection register. A new bit enters at the least significant end, so the first bit of an eight-bit frame ends up in the most significant position. A frame may be shorter or longer than eight bits, and the register keeps whatever eight bits were shifted in last.

When the frame line rises, the enable register copies the collection register in one step. At the same time the block gives a one-cycle update strobe and a mask of the enable bits that changed. A bit that keeps its value does not move.

On each rising serial-clock edge inside a frame, the serial data output presents the most significant bit of the collection register. Devices can therefore be chained: the output stream is the input stream delayed by eight captures.

Top module: `sw_serial_ctrl`

## Requirements
- R1: After reset, `sw_en_o` is all zeros, `sdo_o` is 0, `upd_o` is 0, `chg_mask_o` is all zeros, and the collection register is all zeros.
- R2: While `frame_n_i` is low, each falling edge of `sclk_i` shifts `sdi_i` into bit 0 of the collection register, and every stored bit moves one place toward bit 7. After eight captures, the first bit sent sits in bit 7.
- R3: `sw_en_o[7]` drives switch 8 and `sw_en_o[0]` drives switch 1. A 1 turns a switch on and a 0 turns it off.
- R4: A frame of fewer than eight bits leaves the older bits shifted up, and a frame of more than eight bits keeps only its last eight bits. In both cases the collection register holds the last eight bits captured.
- R5: While `frame_n_i` is high, activity on `sclk_i` and `sdi_i` changes neither the collection register nor `sdo_o`.
- R6: `sw_en_o` changes only on the update that follows a rising edge of `frame_n_i`, and it holds steady during a frame.
- R7: Each rising edge of `frame_n_i` produces exactly one `upd_o` pulse, one system clock wide, and that pulse comes in the same cycle as the new `sw_en_o`. A frame with no captured bits still reloads the unchanged contents.
- R8: During the `upd_o` cycle, `chg_mask_o` equals the new `sw_en_o` XOR the previous `sw_en_o`. Bits that keep their value, including enables that stay on, do not toggle.
- R9: On each rising edge of `sclk_i` while `frame_n_i` is low, `sdo_o` takes bit 7 of the collection register, and it holds that value at all other times.
- R10: Any pattern of enables is accepted, including all on (0xFF) and all off (0x00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous to `clk` |
| frame_n_i | input | 1 | Active-low frame line; its rising edge commits the enables |
| sdi_i | input | 1 | Serial data in, captured on falling `sclk_i` edges |
| sdo_o | output | 1 | Serial data out for chaining, updated on rising `sclk_i` edges |
| sw_en_o | output | NSW | Switch enables; bit 7 is switch 8, bit 0 is switch 1 |
| upd_o | output | 1 | One-cycle strobe marking an enable update |
| chg_mask_o | output | NSW | Enable bits that changed in the current update |

## Verification
A collection register holding the wrong value is hidden until the frame ends. It then shows at once in `sw_en_o` and `chg_mask_o` during the `upd_o` cycle. It also shows in `sdo_o` within one serial-clock period, because `sdo_o` takes the top bit on every rising edge. A wrong enable register shows in the next change mask, since the mask is compared with the enables the bench last expected. A missing or doubled update shows as a mismatch between the bench's queue of expected updates and the `upd_o` pulses the design produces.

// File: rtl/sw_serial_ctrl.sv
module sw_serial_ctrl #(
  parameter int NSW      = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_i,
  input  logic           frame_n_i,
  input  logic           sdi_i,
  output logic           sdo_o,
  output logic [NSW-1:0] sw_en_o,
  output logic           upd_o,
  output logic [NSW-1:0] chg_mask_o
);

  localparam int MSB = NSW - 1;

  logic [SYNC_LEN-1:0] sclk_sy, frm_sy, sdi_sy;
  logic                sclk_q, frm_q;
  logic [NSW-1:0]      sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_sy <= '1;
      frm_sy  <= '1;
      sdi_sy  <= '0;
      sclk_q  <= 1'b1;
      frm_q   <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_LEN-2:0], sclk_i};
      frm_sy  <= {frm_sy[SYNC_LEN-2:0], frame_n_i};
      sdi_sy  <= {sdi_sy[SYNC_LEN-2:0], sdi_i};
      sclk_q  <= sclk_sy[SYNC_LEN-1];
      frm_q   <= frm_sy[SYNC_LEN-1];
    end
  end

  wire sclk_s    = sclk_sy[SYNC_LEN-1];
  wire frm_s     = frm_sy[SYNC_LEN-1];
  wire sdi_s     = sdi_sy[SYNC_LEN-1];
  wire active    = !frm_s;
  wire sclk_fall = sclk_q && !sclk_s;
  wire sclk_rise = !sclk_q && sclk_s;
  wire frm_rise  = !frm_q && frm_s;

  always_ff @(posedge clk) begin
    if (!rst_n)                  sr <= '0;
    else if (active && sclk_fall) sr <= {sr[MSB-1:0], sdi_s};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   sdo_o <= 1'b0;
    else if (active && sclk_rise) sdo_o <= sr[MSB];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_en_o    <= '0;
      upd_o      <= 1'b0;
      chg_mask_o <= '0;
    end else begin
      upd_o <= frm_rise;
      if (frm_rise) begin
        sw_en_o    <= sr;
        chg_mask_o <= sr ^ sw_en_o;
      end
    end
  end

  p_idle_no_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_s |=> $stable(sr));

  p_en_only_on_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_en_o) |-> upd_o);

  p_upd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  p_mask_delta_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (chg_mask_o == (sw_en_o ^ $past(sw_en_o))));

  p_sdo_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> $past(sclk_rise && active));

  p_upd_after_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(frm_rise));

endmodule

// File: tb/sw_serial_ctrl_bench.sv
module sw_serial_ctrl_bench;
  localparam int NSW = 8;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_i = 1'b1, frame_n_i = 1'b1, sdi_i = 1'b0;
  logic sdo_o, upd_o;
  logic [NSW-1:0] sw_en_o, chg_mask_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [NSW-1:0] model_sr = '0;
  logic [NSW-1:0] model_en = '0;
  logic model_sdo = 1'b0;
  logic [2*NSW-1:0] exp_q[$];

  always #2 clk = ~clk;

  sw_serial_ctrl #(.NSW(NSW)) u_sw_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .frame_n_i(frame_n_i),
    .sdi_i(sdi_i), .sdo_o(sdo_o), .sw_en_o(sw_en_o), .upd_o(upd_o),
    .chg_mask_o(chg_mask_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi_i = bits[i];
      wait_clk(HALF);
      sclk_i = 1'b0;
      model_sr = {model_sr[NSW-2:0], bits[i]};
      wait_clk(HALF);
      sclk_i = 1'b1;
      model_sdo = model_sr[NSW-1];
      wait_clk(HALF);
      check("R9 sdo", sdo_o, model_sdo);
      check("R6 en steady in frame", sw_en_o, model_en);
    end
  endtask

  task automatic frame(input logic [31:0] bits, input int n);
    frame_n_i = 1'b0;
    wait_clk(HALF);
    send_bits(bits, n);
    exp_q.push_back({model_sr, model_sr ^ model_en});
    model_en = model_sr;
    frame_n_i = 1'b1;
    wait_clk(4 * HALF);
    check("R7 update consumed", exp_q.size(), 0);
  endtask

  int upd_w = 0;
  always @(negedge clk) begin
    if (rst_n && upd_o) begin
      logic [2*NSW-1:0] e;
      upd_w++;
      check("R7 single-cycle strobe", upd_w, 1);
      if (exp_q.size() == 0) begin
        check("R7 unexpected update", 1, 0);
      end else begin
        e = exp_q.pop_front();
        check("R2 R4 enables", sw_en_o, e[2*NSW-1:NSW]);
        check("R8 change mask", chg_mask_o, e[NSW-1:0]);
      end
    end else begin
      upd_w = 0;
    end
  end

  initial begin
    wait_clk(200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    check("R1 sw_en", sw_en_o, 0);
    check("R1 sdo", sdo_o, 0);
    check("R1 upd", upd_o, 0);
    check("R1 mask", chg_mask_o, 0);

    // R2 R3: first bit lands in bit 7 (switch 8)
    frame(32'h80, 8);
    check("R3 switch 8 on", sw_en_o[7], 1'b1);
    check("R3 switch 1 off", sw_en_o[0], 1'b0);
    frame(32'hA5, 8);
    // R10 all on, then all off; R8 stay-on bits do not toggle
    frame(32'hFF, 8);
    frame(32'hF0, 8);
    check("R8 kept-on bits", chg_mask_o[7:4], 4'h0);
    frame(32'h00, 8);
    check("R10 all off", sw_en_o, 8'h00);
    // R4 short frame then long frame; R9 chained stream
    frame(32'hC3, 8);
    frame(32'h5, 3);
    frame(32'h1234, 16);
    check("R4 last eight kept", sw_en_o, 8'h34);

    // R5: activity with frame idle is ignored
    for (int k = 0; k < 6; k++) begin
      sdi_i = k[0];
      wait_clk(HALF); sclk_i = 1'b0;
      wait_clk(HALF); sclk_i = 1'b1;
    end
    wait_clk(HALF);
    check("R5 sdo unchanged", sdo_o, model_sdo);
    check("R5 en unchanged", sw_en_o, model_en);
    // R7 zero-bit frame reloads unchanged contents
    frame(32'h0, 0);
    check("R5 R7 reload same", sw_en_o, 8'h34);
    check("R7 zero-bit mask", chg_mask_o, 8'h00);

    wait_clk(8);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule